// File: doc/BRIEF.md
# Edge-Captured Interrupt Flag Controller

This block sits beside a host processor on a 16-bit register bus and combines several external request lines into a single interrupt output. Each live request line is synchronised and watched for rising edges. A detected edge latches a pending bit that stays set until software clears it. A mask register, in which a one blocks a source, decides which pending bits may drive the combined output. Software reads the pending bits to find out which sources fired. It then clears those bits by writing zeros to them. Any bit written as one is left unchanged.

Three sources are live, on bit positions 8, 9 and 10 of both registers. The pending register is at byte offset 0x02 and the mask register is at byte offset 0x0A. Reads are synchronous. A read strobe captures the addressed register into the read-data output, which then holds that value until the next read.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0x0700, the pending register reads 0x0000, `irq_o` is low and `bus_rdata` is 0x0000.
- R2: A rising edge on `req_i[k]` sets pending bit 8+k. The bit is visible in the register on the third rising clock edge after the input is first sampled high. Bit k of `req_i` maps to register bit 8+k.
- R3: A pending bit stays set after its request line falls, and a line held high sets it only once.
- R4: A write to offset 0x02 clears each live pending bit whose write-data bit is 0 and leaves unchanged each bit whose write-data bit is 1. Writing 0xFFFF clears nothing.
- R5: If an edge is detected in the same cycle as a write that clears its pending bit, the bit is set after that edge.
- R6: A write to offset 0x0A loads mask bits 10:8 from write-data bits 10:8, and a read of offset 0x0A returns them. A mask bit of 1 blocks its source from `irq_o`.
- R7: Register bits outside 10:8 always read 0 and ignore writes. Reads of any offset other than 0x02 or 0x0A return 0.
- R8: `irq_o` is a register. It is high in the cycle after any live bit of (pending AND NOT mask) was 1, and low otherwise.
- R9: Pending bits latch while their source is masked. Clearing the mask bit of a pending source raises `irq_o` one cycle after the mask write.
- R10: When `bus_rd` is high at a clock edge, `bus_rdata` takes the value of the register at `bus_addr` as it stood before that edge. Otherwise `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 3 | Asynchronous request lines, bit k feeds register bit 8+k |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined registered interrupt output |

## Verification
The hardest case to reach is an edge arriving in exactly the cycle of a write that clears the same pending bit. The synchroniser delays the edge by two cycles, so a naive bench almost never lines the two up. A directed sequence raises a request line and issues the clearing write precisely two cycles later. Thousands of cycles of random request toggling, mixed with random writes and reads, then hit the same overlap on many bit combinations. A cycle-accurate reference in the bench follows the stated latencies and predicts both outputs every cycle.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int SRC_N    = 3,
  parameter int SRC_LSB  = 8,
  parameter int FLAG_OFS = 2,
  parameter int MASK_OFS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  req_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq_o
);
  localparam int SRC_MSB = SRC_LSB + SRC_N - 1;

  logic [SRC_N-1:0] sync1_q, sync2_q, prev_q, flag_q, mask_q;
  logic [SRC_N-1:0] edge_w, keep_w;
  logic             hit_flag, hit_mask;
  logic [15:0]      view_w;

  assign hit_flag = bus_addr == ADDR_W'(FLAG_OFS);
  assign hit_mask = bus_addr == ADDR_W'(MASK_OFS);
  assign edge_w   = sync2_q & ~prev_q;
  assign keep_w   = (bus_wr && hit_flag) ? bus_wdata[SRC_MSB:SRC_LSB] : '1;
  assign view_w   = hit_flag ? (16'(flag_q) << SRC_LSB) :
                    hit_mask ? (16'(mask_q) << SRC_LSB) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q   <= '0;
      sync2_q   <= '0;
      prev_q    <= '0;
      flag_q    <= '0;
      mask_q    <= '1;
      irq_o     <= 1'b0;
      bus_rdata <= 16'h0000;
    end else begin
      sync1_q <= req_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      flag_q  <= (flag_q & keep_w) | edge_w;
      if (bus_wr && hit_mask) mask_q <= bus_wdata[SRC_MSB:SRC_LSB];
      irq_o <= |(flag_q & ~mask_q);
      if (bus_rd) bus_rdata <= view_w;
    end
  end
endmodule

module edge_irq_ctrl_chk #(
  parameter int ADDR_W   = 4,
  parameter int SRC_N    = 3,
  parameter int SRC_LSB  = 8,
  parameter int FLAG_OFS = 2,
  parameter int MASK_OFS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              irq_o,
  input logic [SRC_N-1:0]  flag_q,
  input logic [SRC_N-1:0]  mask_q,
  input logic [SRC_N-1:0]  edge_w
);
  localparam logic [15:0] LIVE = 16'(((1 << SRC_N) - 1) << SRC_LSB);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(FLAG_OFS)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4
  ones_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(FLAG_OFS) && (bus_wdata & LIVE) == LIVE)
      |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R5
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_w) |=> ((flag_q & $past(edge_w)) == $past(edge_w)));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(MASK_OFS)) |=> (mask_q == $past(bus_wdata[SRC_LSB+SRC_N-1:SRC_LSB])));

  // R7
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE) == 16'h0000);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_o == $past(|(flag_q & ~mask_q))));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .SRC_N(SRC_N), .SRC_LSB(SRC_LSB), .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .flag_q(flag_q), .mask_q(mask_q), .edge_w(edge_w)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req_i = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // reference state, per the requirements
  logic [2:0]  m_s1 = 0, m_s2 = 0, m_prev = 0, m_flag = 0, m_mask = 3'b111;
  logic        m_irq = 0;
  logic [15:0] m_rdata = 0;

  edge_irq_ctrl i_edge_irq_ctrl (.clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  function automatic logic [15:0] reg_view(input logic [3:0] a);
    if (a == 4'h2) return {5'b0, m_flag, 8'b0};
    if (a == 4'hA) return {5'b0, m_mask, 8'b0};
    return 16'h0000;
  endfunction

  task automatic compare();
    n_vec++;
    if (irq_o !== m_irq) begin
      n_bad++;
      $display("FAIL %s (R8) irq_o actual %b expected %b", tag, irq_o, m_irq);
    end
    n_vec++;
    if (bus_rdata !== m_rdata) begin
      n_bad++;
      $display("FAIL %s (R10) bus_rdata actual %h expected %h", tag, bus_rdata, m_rdata);
    end
  endtask

  task automatic step(input logic [2:0] r, input logic wr, input logic rd,
                      input logic [3:0] a, input logic [15:0] d);
    logic [2:0] e;
    @(negedge clk);
    compare();
    req_i = r; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    e = m_s2 & ~m_prev;
    if (rd) m_rdata = reg_view(a);
    m_irq = |(m_flag & ~m_mask);
    m_flag = (wr && a == 4'h2) ? ((m_flag & d[10:8]) | e) : (m_flag | e);
    if (wr && a == 4'hA) m_mask = d[10:8];
    m_prev = m_s2; m_s2 = m_s1; m_s1 = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(req_i, 0, 0, 4'h0, 16'h0);
  endtask

  task automatic rd_reg(input logic [3:0] a);
    step(req_i, 0, 1, a, 16'h0);
    step(req_i, 0, 0, a, 16'h0);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1"; idle(1); rd_reg(4'hA); rd_reg(4'h2);
    tag = "R2"; step(3'b001, 0, 0, 0, 0); idle(4); rd_reg(4'h2);
    tag = "R3"; step(3'b000, 0, 0, 0, 0); idle(4); step(3'b001, 0, 0, 0, 0);
    step(3'b000, 0, 0, 0, 0); idle(3); rd_reg(4'h2);
    tag = "R4"; step(3'b000, 1, 0, 4'h2, 16'hFFFF); rd_reg(4'h2);
    step(3'b000, 1, 0, 4'h2, 16'hFEFF); rd_reg(4'h2);
    tag = "R5"; step(3'b010, 0, 0, 0, 0); idle(1);
    step(3'b010, 1, 0, 4'h2, 16'h0000); idle(1); rd_reg(4'h2);
    tag = "R9"; step(3'b110, 0, 0, 0, 0); idle(5); rd_reg(4'h2);
    step(3'b110, 1, 0, 4'hA, 16'h0300); idle(3);
    tag = "R6"; rd_reg(4'hA); step(3'b000, 1, 0, 4'hA, 16'h0000); idle(2); rd_reg(4'hA);
    tag = "R7"; step(3'b000, 1, 0, 4'hA, 16'hFFFF); rd_reg(4'hA);
    step(3'b000, 1, 0, 4'h4, 16'hFFFF); rd_reg(4'h4); rd_reg(4'h0);
    step(3'b000, 1, 0, 4'h2, 16'h0000); rd_reg(4'h2);
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      a = ($urandom % 3 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'h2 : 4'hA);
      step(($urandom % 4 == 0) ? 3'($urandom) : req_i, ($urandom % 6) == 0,
           ($urandom % 3) == 0, a, 16'($urandom));
    end
    idle(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule